// File: doc/BRIEF.md
# Coprocessor Transfer Address Sequencer

This block sits on the host core side of a coprocessor load/store path. A 32-bit instruction word is presented with an issue strobe. The block checks the encoding class and works out the effective base and the offset-adjusted base. It then drives one bus word address per transfer word. The coprocessor decides how many words move: it raises an advance strobe for each word it supplies or accepts, and a last-word signal with the final one.

When the transfer ends, normally or through a memory abort, the block offers the adjusted base for write-back to the base register. It does this only if the instruction asked for write-back. A counter reports how many cycles the most recent instruction took, so that timing can be checked against the expected cost. A condition-pass input lets the core cancel an instruction that should not run. Illegal encodings raise a one-cycle flag and start no bus activity.

Top module: `cpxfer_addr_seq`

## Requirements
- R1: An issued word whose bits [27:25] differ from 3'b110 raises `illegal_o` for the one cycle after issue, and starts no bus cycle and no write-back.
- R2: The adjusted base equals the effective base plus four times the 8-bit field in bits [7:0] when bit 23 is 1, and the effective base minus that amount when bit 23 is 0.
- R3: With bit 24 set, the first bus address is the adjusted base. With bit 24 clear, the first bus address is the unadjusted effective base.
- R4: Write-back happens only when bit 21 is set, for both pre- and post-indexed forms. `wb_en_o` pulses for the one cycle after the transfer ends, and `wb_val_o` then carries the adjusted base.
- R5: Each later word uses the address 4 above the previous word, whatever the value of bit 23.
- R6: When the base field in bits [19:16] is 15, the effective base is `pc_i` + 8. A base field of 15 with bit 21 set is illegal and is handled as in R1.
- R7: The two low bits of every bus address are carried from the computed address unchanged and are never forced to zero.
- R8: `mem_abort_i` during a bus cycle ends the transfer at that edge. The requested write-back still takes place.
- R9: After a transfer of n words with b wait cycles, `cyc_cnt_o` reads (n-1)+2+b.
- R10: When `cond_pass_i` is low at issue, the block makes no bus cycle and no write-back.
- R11: `bus_read_o` is 1 (load into the coprocessor) when bit 20 is 1 and 0 (store from the coprocessor) when bit 20 is 0. It holds steady for the whole transfer.
- R12: A bus cycle without `cp_adv_i` is a wait: the address holds and the transfer continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | Instruction presented this cycle (taken when idle) |
| instr_i | input | 32 | Instruction word |
| base_i | input | 32 | Base register value |
| pc_i | input | 32 | Address of the instruction |
| cond_pass_i | input | 1 | Condition passed for this instruction |
| cp_adv_i | input | 1 | Coprocessor moves a word this cycle |
| cp_last_i | input | 1 | The word moved this cycle is the last |
| mem_abort_i | input | 1 | Memory aborts the current bus cycle |
| bus_addr_o | output | 32 | Byte address of the current word |
| bus_valid_o | output | 1 | A bus cycle is in progress |
| bus_read_o | output | 1 | 1 = read from memory, 0 = write to memory |
| wb_en_o | output | 1 | Base register write-back strobe |
| wb_val_o | output | 32 | Value to write back |
| illegal_o | output | 1 | Illegal encoding pulse |
| cyc_cnt_o | output | 8 | Cycle count of the latest instruction |

## Verification
The bench covers the down-counting post-indexed case, where a design that applied the direction bit to the word step would walk downward instead of upward. It also covers the program-counter base, where a missing +8 shifts every address by two words. A misaligned base shows whether the low address bits are dropped. An abort in the middle of a multi-word transfer shows whether a design drops the write-back or keeps driving the bus. Transfers with and without write-back in both indexing forms catch a design that writes back automatically after post-indexing. Wait cycles check both the held address and the cycle count.

// File: rtl/cpxfer_pkg.sv
package cpxfer_pkg;

  localparam logic [2:0] CPX_CLASS = 3'b110;
  localparam int unsigned PC_AHEAD = 8;
  localparam int unsigned STEP_BYTES = 4;

  // Field order follows the instruction bit layout, MSB first.
  typedef struct packed {
    logic [3:0] cond;
    logic [2:0] cls;
    logic       pre;
    logic       up;
    logic       len;
    logic       wback;
    logic       load;
    logic [3:0] rn;
    logic [3:0] crd;
    logic [3:0] cpn;
    logic [7:0] off;
  } cpx_fields_t;

  function automatic logic [31:0] word_offset(input logic [7:0] off);
    return {22'd0, off, 2'b00};
  endfunction

  function automatic logic [31:0] apply_offset(input logic [31:0] base,
                                               input logic [31:0] delta,
                                               input logic up);
    return up ? (base + delta) : (base - delta);
  endfunction

endpackage

// File: rtl/cpxfer_decode.sv
module cpxfer_decode
  import cpxfer_pkg::*;
(
  input  logic [31:0] instr_i,
  output cpx_fields_t fld_o,
  output logic        illegal_o
);
  logic bad_class;
  logic pc_wback;

  assign fld_o     = cpx_fields_t'(instr_i);
  assign bad_class = (fld_o.cls != CPX_CLASS);
  assign pc_wback  = fld_o.wback && (fld_o.rn == 4'd15);
  assign illegal_o = bad_class || pc_wback;
endmodule

// File: rtl/cpxfer_addr_gen.sv
module cpxfer_addr_gen
  import cpxfer_pkg::*;
(
  input  cpx_fields_t fld_i,
  input  logic [31:0] base_i,
  input  logic [31:0] pc_i,
  output logic [31:0] first_o,
  output logic [31:0] adj_o
);
  logic [31:0] eff_base;

  assign eff_base = (fld_i.rn == 4'd15) ? (pc_i + 32'(PC_AHEAD)) : base_i;
  assign adj_o    = apply_offset(eff_base, word_offset(fld_i.off), fld_i.up);
  assign first_o  = fld_i.pre ? adj_o : eff_base;
endmodule

// File: rtl/cpxfer_seq.sv
module cpxfer_seq
  import cpxfer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic             cond_pass_i,
  input  logic             illegal_i,
  input  logic             load_i,
  input  logic             wback_i,
  input  logic [31:0]      first_i,
  input  logic [31:0]      adj_i,
  input  logic             cp_adv_i,
  input  logic             cp_last_i,
  input  logic             mem_abort_i,
  output logic [31:0]      bus_addr_o,
  output logic             bus_valid_o,
  output logic             bus_read_o,
  output logic             wb_en_o,
  output logic [31:0]      wb_val_o,
  output logic             illegal_o,
  output logic [CNT_W-1:0] cyc_cnt_o
);
  logic busy_q, wpend_q;
  logic accept, launch, xfer_end, step;

  assign accept   = !busy_q && issue_i;
  assign launch   = accept && !illegal_i && cond_pass_i;
  assign xfer_end = busy_q && (mem_abort_i || (cp_adv_i && cp_last_i));
  assign step     = busy_q && cp_adv_i && !xfer_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q     <= 1'b0;
      wpend_q    <= 1'b0;
      bus_addr_o <= '0;
      bus_read_o <= 1'b0;
      wb_en_o    <= 1'b0;
      wb_val_o   <= '0;
      illegal_o  <= 1'b0;
      cyc_cnt_o  <= '0;
    end else begin
      wb_en_o   <= 1'b0;
      illegal_o <= 1'b0;
      if (accept) begin
        illegal_o <= illegal_i;
        cyc_cnt_o <= CNT_W'(1);
      end
      if (launch) begin
        busy_q     <= 1'b1;
        bus_addr_o <= first_i;
        bus_read_o <= load_i;
        wpend_q    <= wback_i;
        wb_val_o   <= adj_i;
      end
      if (busy_q) cyc_cnt_o <= cyc_cnt_o + CNT_W'(1);
      if (xfer_end) begin
        busy_q  <= 1'b0;
        wb_en_o <= wpend_q;
      end
      if (step) bus_addr_o <= bus_addr_o + 32'(STEP_BYTES);
    end
  end

  assign bus_valid_o = busy_q;

  a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cp_adv_i && !cp_last_i && !mem_abort_i) |=>
      (bus_addr_o == $past(bus_addr_o) + 32'd4));
  a_r12_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !cp_adv_i && !mem_abort_i) |=> (busy_q && $stable(bus_addr_o)));
  a_r8_abort_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && mem_abort_i) |=> !busy_q);
  a_r4_wb_after_end: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> ($past(busy_q) && !busy_q));
  a_r11_dir_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(bus_read_o));
  a_r1_illegal_idle: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !busy_q);
  a_r9_count_runs: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> (cyc_cnt_o == $past(cyc_cnt_o) + CNT_W'(1)));
endmodule

// File: rtl/cpxfer_addr_seq.sv
module cpxfer_addr_seq
  import cpxfer_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic [31:0]      instr_i,
  input  logic [31:0]      base_i,
  input  logic [31:0]      pc_i,
  input  logic             cond_pass_i,
  input  logic             cp_adv_i,
  input  logic             cp_last_i,
  input  logic             mem_abort_i,
  output logic [31:0]      bus_addr_o,
  output logic             bus_valid_o,
  output logic             bus_read_o,
  output logic             wb_en_o,
  output logic [31:0]      wb_val_o,
  output logic             illegal_o,
  output logic [CNT_W-1:0] cyc_cnt_o
);
  cpx_fields_t fld;
  logic        dec_illegal;
  logic [31:0] first_addr, adj_base;

  cpxfer_decode u_dec (
    .instr_i   (instr_i),
    .fld_o     (fld),
    .illegal_o (dec_illegal)
  );

  cpxfer_addr_gen u_agen (
    .fld_i   (fld),
    .base_i  (base_i),
    .pc_i    (pc_i),
    .first_o (first_addr),
    .adj_o   (adj_base)
  );

  cpxfer_seq #(.CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue_i     (issue_i),
    .cond_pass_i (cond_pass_i),
    .illegal_i   (dec_illegal),
    .load_i      (fld.load),
    .wback_i     (fld.wback),
    .first_i     (first_addr),
    .adj_i       (adj_base),
    .cp_adv_i    (cp_adv_i),
    .cp_last_i   (cp_last_i),
    .mem_abort_i (mem_abort_i),
    .bus_addr_o  (bus_addr_o),
    .bus_valid_o (bus_valid_o),
    .bus_read_o  (bus_read_o),
    .wb_en_o     (wb_en_o),
    .wb_val_o    (wb_val_o),
    .illegal_o   (illegal_o),
    .cyc_cnt_o   (cyc_cnt_o)
  );
endmodule

// File: tb/sim_cpxfer_addr_seq.sv
module sim_cpxfer_addr_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue = 1'b0, cond = 1'b1, adv = 1'b0, last = 1'b0, abrt = 1'b0;
  logic [31:0] instr = '0, base = '0, pc = '0;
  logic [31:0] bus_addr, wb_val;
  logic bus_valid, bus_read, wb_en, illegal;
  logic [7:0] cyc_cnt;

  int n_chk = 0;
  int n_fail = 0;
  logic [32:0] expq[$];

  always #5 clk = ~clk;

  cpxfer_addr_seq u0 (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .instr_i(instr), .base_i(base),
    .pc_i(pc), .cond_pass_i(cond), .cp_adv_i(adv), .cp_last_i(last),
    .mem_abort_i(abrt), .bus_addr_o(bus_addr), .bus_valid_o(bus_valid),
    .bus_read_o(bus_read), .wb_en_o(wb_en), .wb_val_o(wb_val),
    .illegal_o(illegal), .cyc_cnt_o(cyc_cnt)
  );

  task automatic chk(input string req, input logic [32:0] act, input logic [32:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: each bus cycle where a word moves is compared with the queue.
  always @(negedge clk) begin
    if (rst_n && bus_valid && adv) begin
      if (expq.size() == 0) chk("R5 unexpected bus word", {bus_read, bus_addr}, 33'h0);
      else chk("R3/R5/R7/R11 bus word", {bus_read, bus_addr}, expq.pop_front());
    end
  end

  function automatic logic [31:0] mk(input logic [2:0] cls, input bit p, input bit u,
                                     input bit w, input bit l, input logic [3:0] rn,
                                     input logic [7:0] off);
    return {4'he, cls, p, u, 1'b0, w, l, rn, 4'h2, 4'h1, off};
  endfunction

  task automatic run(input logic [31:0] ins, input logic [31:0] b, input logic [31:0] p,
                     input bit cnd, input int n, input int wt, input int ab_at,
                     input string tag);
    bit ill, w;
    logic [31:0] eff, adj, addr;
    int xc;
    int off_bytes;
    w = ins[21];
    ill = (ins[27:25] != 3'b110) || (w && ins[19:16] == 4'd15);
    eff = (ins[19:16] == 4'd15) ? p + 32'd8 : b;
    off_bytes = int'(ins[7:0]) * 4;
    adj = ins[23] ? eff + 32'(off_bytes) : eff - 32'(off_bytes);
    addr = ins[24] ? adj : eff;
    @(posedge clk); #1;
    issue = 1'b1; instr = ins; base = b; pc = p; cond = cnd;
    @(posedge clk); #1;
    issue = 1'b0;
    if (ill || !cnd) begin
      @(negedge clk);
      chk({tag, " R1/R6 illegal flag"}, {32'd0, illegal}, {32'd0, ill});
      chk({tag, " R10 no bus cycle"}, {32'd0, bus_valid}, 33'd0);
      @(negedge clk);
      chk({tag, " R10 no write-back"}, {32'd0, wb_en}, 33'd0);
      chk({tag, " R1 flag is one cycle"}, {32'd0, illegal}, 33'd0);
      return;
    end
    xc = 0;
    for (int k = 0; k < n; k++) begin
      if (k == n - 1) begin
        for (int j = 0; j < wt; j++) begin
          adv = 1'b0; last = 1'b0;
          @(negedge clk);
          chk({tag, " R12 wait holds address"}, {1'b0, bus_addr}, {1'b0, addr});
          @(posedge clk); #1;
          xc++;
        end
      end
      adv = 1'b1; last = (k == n - 1); abrt = (k == ab_at);
      expq.push_back({ins[20], addr});
      addr = addr + 32'd4;
      @(posedge clk); #1;
      xc++;
      if (k == ab_at) break;
    end
    adv = 1'b0; last = 1'b0; abrt = 1'b0;
    @(negedge clk);
    chk({tag, " R4/R8 write-back strobe"}, {32'd0, wb_en}, {32'd0, w});
    if (w) chk({tag, " R2/R4 write-back value"}, {1'b0, wb_val}, {1'b0, adj});
    chk({tag, " R8 bus released"}, {32'd0, bus_valid}, 33'd0);
    chk({tag, " R9 cycle count"}, {25'd0, cyc_cnt}, 33'(xc + 1));
    chk({tag, " R5 queue drained"}, 33'(expq.size()), 33'd0);
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    @(negedge clk);
    chk("R4 reset wb_en", {32'd0, wb_en}, 33'd0);
    chk("R10 reset bus idle", {32'd0, bus_valid}, 33'd0);
    chk("R1 reset illegal", {32'd0, illegal}, 33'd0);
    rst_n = 1'b1;
    // R2 R3 R11: pre-indexed up, load, one word, write-back
    run(mk(3'b110, 1, 1, 1, 1, 4'd3, 8'd3), 32'h1000, 32'h0, 1, 1, 0, -1, "pre-up-load");
    // R3 R5 R12: post-indexed down, store, three words, waits, write-back
    run(mk(3'b110, 0, 0, 1, 0, 4'd4, 8'd2), 32'h2000, 32'h0, 1, 3, 2, -1, "post-down-store");
    // R4: pre-indexed down without write-back
    run(mk(3'b110, 1, 0, 0, 1, 4'd5, 8'd1), 32'h3000, 32'h0, 1, 2, 0, -1, "pre-down-nowb");
    // R4: post-indexed without write-back: nothing automatic
    run(mk(3'b110, 0, 1, 0, 0, 4'd6, 8'd9), 32'h3800, 32'h0, 1, 2, 1, -1, "post-nowb");
    // R6: program-counter base
    run(mk(3'b110, 1, 1, 0, 1, 4'd15, 8'd1), 32'hdead0000, 32'h400, 1, 2, 0, -1, "pc-base");
    // R6: write-back to the program counter is illegal
    run(mk(3'b110, 1, 1, 1, 1, 4'd15, 8'd1), 32'h0, 32'h400, 1, 1, 0, -1, "pc-wb");
    // R1: wrong class bits
    run(mk(3'b111, 1, 1, 0, 1, 4'd2, 8'd1), 32'h4000, 32'h0, 1, 1, 0, -1, "bad-class");
    // R10: condition failed
    run(mk(3'b110, 1, 1, 1, 1, 4'd2, 8'd1), 32'h4000, 32'h0, 0, 1, 0, -1, "cond-fail");
    // R8: abort on the second of three words, write-back kept
    run(mk(3'b110, 1, 1, 1, 0, 4'd7, 8'd4), 32'h6000, 32'h0, 1, 3, 0, 1, "abort");
    // R7: misaligned base, post-indexed
    run(mk(3'b110, 0, 1, 1, 1, 4'd8, 8'd1), 32'h5003, 32'h0, 1, 2, 0, -1, "misaligned");
    repeat (3) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule